// File: doc/BRIEF.md
# Serial Command Port with Daisy-Chain Output

This block is the serial front end of a peripheral controller. A host drives 16-bit command words into it over a four-wire SPI link. Chip select is active low and SCLK idles low. The block samples the data input on falling SCLK edges and changes its data output on rising edges. When chip select is released, the block splits the word it has received into a 3-bit register address and a 13-bit payload. It presents them on a parallel port together with a one-cycle write strobe. The registers behind that port belong to the surrounding logic.

While a command is being shifted in, the block shifts out a 16-bit status word. A status selector, written through address 7 of the same link, picks that word from eight inputs. The top bit of the returned word is replaced by a framing-error flag. If a frame carries 32, 48 or more clocks, the data output acts as a 16-bit delay of the data input. Several devices can therefore share one chip select in a chain.

All three pins pass through synchronizers clocked by the system clock. The system clock must run at least four times faster than SCLK. The host must leave chip select high for at least six system cycles between frames.

Top module: `spi_cmd_if`

## Requirements
- R1: Words travel MSB first. On chip-select release after a valid frame, `wr_stb_o` pulses with `wr_addr_o` equal to bits 15:13 and `wr_data_o` equal to bits 12:0 of the last 16 bits received. The strobe only occurs while chip select is inactive.
- R2: The data input is captured only on falling SCLK edges while chip select is low.
- R3: `sdo_o` changes only after a rising SCLK edge, and stays constant through each SCLK high phase and low phase.
- R4: At the first rising edge of a frame, the output shifter loads `{err, status[sel][14:0]}`. Status word k occupies `status_i[16k+15:16k]`. The first 16 bits out are that word, MSB first.
- R5: In a frame of 32 clocks, output bits 17 to 32 equal the first 16 input bits, and the word committed is the last 16 input bits.
- R6: `sdo_oe_o` is 0 while chip select is high and 1 while it is low.
- R7: A frame with zero clocks, or with a clock count that is not a multiple of 16, writes nothing and sets the error flag (bit 15 of the next status word). The next valid frame clears the flag.
- R8: A valid write to address 7 sets the status selector to payload bits 2:0. The selector changes on no other event.
- R9: Each write strobe lasts exactly one system clock cycle.
- R10: After reset there is no strobe and the output enable is 0. The selector is 0 and the error flag is 0, including after a reset applied once the selector has been changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the host |
| csn_i | input | 1 | Chip select, active low |
| sdi_i | input | 1 | Serial data in |
| status_i | input | 128 | Eight 16-bit status words, word k at bits 16k+15:16k |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the SO driver (tri-state when 0) |
| wr_stb_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 3 | Register address of the write |
| wr_data_o | output | 13 | Payload of the write |

## Verification
Every pin edge passes through two synchronizer flops and an edge register before any logic sees it. As a result, `sdo_o`, `sdo_oe_o` and the write strobe move three to four system cycles after the pin edge that causes them. The bench holds each SCLK phase for eight system cycles. It reads SO six cycles into a phase, which is after the update from the preceding rising edge and before the next edge. It reads the output enable eight cycles after chip select changes. After chip select rises, the bench watches the write port over a twelve-cycle window and counts how many cycles the strobe is high, so both a missing strobe and a stretched strobe are caught.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
    localparam int WORD_W   = 16;
    localparam int ADDR_W   = 3;
    localparam int DATA_W   = WORD_W - ADDR_W;
    localparam int NSTAT    = 8;
    localparam int SEL_W    = $clog2(NSTAT);
    localparam int CNT_W    = $clog2(WORD_W);
    localparam logic [ADDR_W-1:0] SEL_ADDR = 3'd7;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;

    typedef struct packed {
        logic sclk_rise;
        logic sclk_fall;
        logic cs_start;
        logic cs_end;
        logic cs_idle;
        logic sdi;
    } pin_evt_t;

    function automatic logic [WORD_W-1:0] tag_status(input logic err,
                                                     input logic [WORD_W-1:0] raw);
        return {err, raw[WORD_W-2:0]};
    endfunction
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync
    import spi_cmd_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sclk_i,
    input  logic     csn_i,
    input  logic     sdi_i,
    output pin_evt_t evt_o
);
    // bit order in each stage: {sclk, csn, sdi}
    localparam logic [2:0] IDLE = 3'b010;

    logic [STAGES-1:0][2:0] chain;
    logic [1:0]             prev;   // {sclk, csn} one cycle older
    logic                   sclk_s, csn_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{IDLE}};
            prev  <= 2'b01;
        end else begin
            chain[0] <= {sclk_i, csn_i, sdi_i};
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            prev <= {sclk_s, csn_s};
        end
    end

    assign sclk_s = chain[STAGES-1][2];
    assign csn_s  = chain[STAGES-1][1];

    always_comb begin
        evt_o.sclk_rise = sclk_s & ~prev[1];
        evt_o.sclk_fall = ~sclk_s & prev[1];
        evt_o.cs_start  = ~csn_s & prev[0];
        evt_o.cs_end    = csn_s & ~prev[0];
        evt_o.cs_idle   = csn_s;
        evt_o.sdi       = chain[STAGES-1][0];
    end
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  pin_evt_t          evt,
    input  logic [WORD_W-1:0] load_word,
    output logic [WORD_W-1:0] in_word,
    output logic              frame_ok,
    output logic              sdo,
    output logic              oe
);
    logic [WORD_W-1:0] in_sr, out_sr;
    logic [CNT_W-1:0]  fall_cnt, rise_cnt;
    logic              fall_seen, rise_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_sr     <= '0;
            out_sr    <= '0;
            fall_cnt  <= '0;
            rise_cnt  <= '0;
            fall_seen <= 1'b0;
            rise_seen <= 1'b0;
            oe        <= 1'b0;
        end else begin
            oe <= ~evt.cs_idle;
            if (evt.cs_start) begin
                fall_cnt  <= '0;
                rise_cnt  <= '0;
                fall_seen <= 1'b0;
                rise_seen <= 1'b0;
            end else if (!evt.cs_idle) begin
                if (evt.sclk_fall) begin
                    in_sr     <= {in_sr[WORD_W-2:0], evt.sdi};
                    fall_cnt  <= fall_cnt + 1'b1;
                    fall_seen <= 1'b1;
                end
                if (evt.sclk_rise) begin
                    rise_cnt  <= rise_cnt + 1'b1;
                    rise_seen <= 1'b1;
                    if (rise_cnt == '0)
                        out_sr <= rise_seen ? in_sr : load_word;
                    else
                        out_sr <= {out_sr[WORD_W-2:0], 1'b0};
                end
            end
        end
    end

    assign in_word  = in_sr;
    assign frame_ok = fall_seen && (fall_cnt == '0);
    assign sdo      = out_sr[WORD_W-1];
endmodule

// File: rtl/spi_cmd_commit.sv
module spi_cmd_commit
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_end,
    input  logic              frame_ok,
    input  logic [WORD_W-1:0] in_word,
    output logic              wr_stb,
    output cmd_t              wr_cmd,
    output logic [SEL_W-1:0]  sel_q,
    output logic              err_q
);
    cmd_t rx;
    assign rx = cmd_t'(in_word);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_stb <= 1'b0;
            wr_cmd <= '0;
            sel_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (cs_end) begin
                if (frame_ok) begin
                    wr_stb <= 1'b1;
                    wr_cmd <= rx;
                    err_q  <= 1'b0;
                    if (rx.addr == SEL_ADDR) sel_q <= rx.data[SEL_W-1:0];
                end else begin
                    err_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/spi_cmd_if.sv
module spi_cmd_if
    import spi_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sclk_i,
    input  logic                    csn_i,
    input  logic                    sdi_i,
    input  logic [NSTAT*WORD_W-1:0] status_i,
    output logic                    sdo_o,
    output logic                    sdo_oe_o,
    output logic                    wr_stb_o,
    output logic [ADDR_W-1:0]       wr_addr_o,
    output logic [DATA_W-1:0]       wr_data_o
);
    pin_evt_t          evt;
    logic [WORD_W-1:0] in_word, load_word;
    logic [WORD_W-1:0] stat_arr [NSTAT];
    logic              frame_ok, err_q;
    logic [SEL_W-1:0]  sel_q;
    cmd_t              wr_cmd;

    for (genvar k = 0; k < NSTAT; k++) begin : g_stat
        assign stat_arr[k] = status_i[k*WORD_W +: WORD_W];
    end

    assign load_word = tag_status(err_q, stat_arr[sel_q]);

    spi_cmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .sclk_i(sclk_i), .csn_i(csn_i), .sdi_i(sdi_i),
        .evt_o(evt)
    );

    spi_cmd_shift u_shift (
        .clk(clk), .rst(rst), .evt(evt), .load_word(load_word),
        .in_word(in_word), .frame_ok(frame_ok), .sdo(sdo_o), .oe(sdo_oe_o)
    );

    spi_cmd_commit u_commit (
        .clk(clk), .rst(rst), .cs_end(evt.cs_end), .frame_ok(frame_ok),
        .in_word(in_word), .wr_stb(wr_stb_o), .wr_cmd(wr_cmd),
        .sel_q(sel_q), .err_q(err_q)
    );

    assign wr_addr_o = wr_cmd.addr;
    assign wr_data_o = wr_cmd.data;
endmodule

// File: rtl/spi_cmd_if_chk.sv
module spi_cmd_if_chk
    import spi_cmd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              rise_evt,
    input logic              cs_idle,
    input logic              sdo_o,
    input logic              sdo_oe_o,
    input logic              wr_stb_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [SEL_W-1:0]  sel_q,
    input logic              err_q
);
    p_sdo_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !rise_evt |=> $stable(sdo_o));

    p_oe_off_r6: assert property (@(posedge clk) disable iff (rst)
        cs_idle |=> !sdo_oe_o);

    p_stb_idle_r1: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |-> cs_idle);

    p_stb_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |=> !wr_stb_o);

    p_err_clear_r7: assert property (@(posedge clk) disable iff (rst)
        wr_stb_o |-> !err_q);

    p_sel_write_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(sel_q) |-> (wr_stb_o && wr_addr_o == SEL_ADDR));
endmodule

bind spi_cmd_if spi_cmd_if_chk u_chk (
    .clk(clk), .rst(rst), .rise_evt(evt.sclk_rise), .cs_idle(evt.cs_idle),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .wr_stb_o(wr_stb_o),
    .wr_addr_o(wr_addr_o), .sel_q(sel_q), .err_q(err_q)
);

// File: tb/spi_cmd_if_test.sv
module spi_cmd_if_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sclk_i = 1'b0, csn_i = 1'b1, sdi_i = 1'b0;
    logic [127:0] status_i;
    logic         sdo_o, sdo_oe_o, wr_stb_o;
    logic [2:0]   wr_addr_o;
    logic [12:0]  wr_data_o;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    spi_cmd_if uut (
        .clk(clk), .rst(rst), .sclk_i(sclk_i), .csn_i(csn_i), .sdi_i(sdi_i),
        .status_i(status_i), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
        .wr_stb_o(wr_stb_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
    );

    function automatic logic [15:0] stat(input int k);
        return 16'h2C00 + 16'(k) * 16'h0101;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame of n clocks; bits sent MSB first from bits[n-1].
    task automatic frame(input logic [31:0] bits, input int n,
                         output logic [31:0] got, output int stb_cycles,
                         output logic [15:0] cap, output logic oe_act,
                         output int so_moves);
        got = '0; stb_cycles = 0; cap = '0; so_moves = 0;
        clks(1);
        csn_i = 1'b0;
        clks(8);
        oe_act = sdo_oe_o;
        for (int i = 0; i < n; i++) begin
            logic a;
            sclk_i = 1'b1;
            clks(6);
            a = sdo_o;
            got = {got[30:0], a};
            sdi_i = bits[n-1-i];
            clks(2);
            sclk_i = 1'b0;
            clks(6);
            if (sdo_o !== a) so_moves++;
            clks(2);
        end
        csn_i = 1'b1;
        for (int c = 0; c < 12; c++) begin
            clks(1);
            if (wr_stb_o) begin
                stb_cycles++;
                cap = {wr_addr_o, wr_data_o};
            end
        end
        clks(8);
    endtask

    localparam int NV = 8;
    localparam logic [15:0] VEC [NV] = '{
        16'h2ABC, 16'hE005, 16'h4123, 16'hE002,
        16'h0FFF, 16'hFFFF, 16'hA001, 16'hE000
    };

    initial begin
        logic [31:0] got;
        int          stb, mv;
        logic [15:0] cap;
        logic        oe;
        int          sel_m;
        logic        err_m;

        for (int k = 0; k < 8; k++) status_i[k*16 +: 16] = stat(k);
        clks(4);
        rst = 1'b0;
        clks(4);
        // R10 reset state
        check(sdo_oe_o == 1'b0, "R10 oe after reset", 32'(sdo_oe_o), 0);
        check(wr_stb_o == 1'b0, "R10 strobe after reset", 32'(wr_stb_o), 0);

        sel_m = 0; err_m = 0;
        for (int v = 0; v < NV; v++) begin
            logic [15:0] exp_so;
            exp_so = {err_m, stat(sel_m)[14:0]};
            frame({16'h0, VEC[v]}, 16, got, stb, cap, oe, mv);
            check(got[15:0] == exp_so, "R4 status word out", got, 32'(exp_so));
            check(stb == 1, "R9 strobe length", stb, 1);
            check(cap == VEC[v], "R1/R2 captured word", 32'(cap), 32'(VEC[v]));
            check(mv == 0, "R3 SO held between rises", mv, 0);
            check(oe == 1'b1, "R6 oe while selected", 32'(oe), 1);
            err_m = 0;
            if (VEC[v][15:13] == 3'd7) sel_m = int'(VEC[v][2:0]);
        end
        check(sdo_oe_o == 1'b0, "R6 oe while idle", 32'(sdo_oe_o), 0);

        // R5 daisy chain: 32 clocks
        frame({16'h3456, 16'h5A5A}, 32, got, stb, cap, oe, mv);
        check(got[31:16] == {1'b0, stat(0)[14:0]}, "R5 status first", got[31:16], 32'(stat(0)));
        check(got[15:0] == 16'h3456, "R5 delayed input", got[15:0], 32'h3456);
        check(cap == 16'h5A5A && stb == 1, "R5 last word committed", 32'(cap), 32'h5A5A);

        // R7 bad frame: 10 clocks
        frame(32'h3FF, 10, got, stb, cap, oe, mv);
        check(stb == 0, "R7 short frame no write", stb, 0);
        // R7 zero-clock frame
        frame(32'h0, 0, got, stb, cap, oe, mv);
        check(stb == 0, "R7 empty frame no write", stb, 0);
        // R7 error bit reported, then cleared
        frame({16'h0, 16'h4111}, 16, got, stb, cap, oe, mv);
        check(got[15] == 1'b1, "R7 error flag set", 32'(got[15]), 1);
        check(stb == 1 && cap == 16'h4111, "R7 valid write after error", 32'(cap), 32'h4111);
        frame({16'h0, 16'h4222}, 16, got, stb, cap, oe, mv);
        check(got[15:0] == {1'b0, stat(0)[14:0]}, "R7 error flag cleared", got, 32'(stat(0)));

        // R8 select word 6, observe it
        frame({16'h0, 16'hE006}, 16, got, stb, cap, oe, mv);
        frame({16'h0, 16'h2000}, 16, got, stb, cap, oe, mv);
        check(got[15:0] == {1'b0, stat(6)[14:0]}, "R8 select word 6", got, 32'(stat(6)));
        // R8 write to another address leaves selector alone
        frame({16'h0, 16'hC003}, 16, got, stb, cap, oe, mv);
        check(got[15:0] == {1'b0, stat(6)[14:0]}, "R8 other address ignored", got, 32'(stat(6)));
        frame({16'h0, 16'h2000}, 16, got, stb, cap, oe, mv);
        check(got[15:0] == {1'b0, stat(6)[14:0]}, "R8 selector kept", got, 32'(stat(6)));

        // R10 reset returns selector and error flag to 0
        frame(32'h5, 5, got, stb, cap, oe, mv);
        clks(1); rst = 1'b1; clks(3); rst = 1'b0; clks(4);
        check(sdo_oe_o == 1'b0 && wr_stb_o == 1'b0, "R10 outputs after reset", 32'(sdo_oe_o), 0);
        frame({16'h0, 16'h2000}, 16, got, stb, cap, oe, mv);
        check(got[15:0] == {1'b0, stat(0)[14:0]}, "R10 selector and flag reset", got, 32'(stat(0)));

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule